// File: doc/BRIEF.md
# USB Low/Full-Speed Line State Decoder

This block turns the two synchronised data lines of a low-speed or full-speed USB segment into a bus state once per bit time. A bit-time strobe from the clock-recovery logic sets when each sample is taken. Each sample becomes one of four codes: single-ended zero, single-ended one, J or K. The speed select decides which of the two differential levels counts as J and which counts as K.

On top of this classification the block tracks framing. It raises an idle indication once the bus has rested at J for two bit times. It gives a start-of-packet pulse when a K follows that idle period. It gives an end-of-packet pulse when an SE0 of at least one bit is followed by J. A mode input lets the J complete the end-of-packet on its first sample, instead of only after it has been held for a whole bit. An SE1 sample is an illegal level and raises an error pulse. Downstream logic (NRZI decode, unstuffing, packet assembly) uses the line code and the pulses directly.

Top module: `usb_line_state_decoder`

## Requirements
- R1: `line_state_o` takes the class of the lines sampled on a strobe in the clock cycle after that strobe, and holds it until the next strobe. The encoding is 00 = SE0 (both lines low), 01 = J, 10 = K, 11 = SE1 (both lines high).
- R2: With `low_speed_i` = 1, D+ low with D- high gives J (01), and D+ high with D- low gives K (10).
- R3: With `low_speed_i` = 0, D+ high with D- low gives J (01), and D+ low with D- high gives K (10).
- R4: A sample with both lines high produces a one-cycle pulse on `se1_err_o` in the cycle after its strobe. No other sample produces this pulse.
- R5: `idle_o` is high exactly when the two most recent samples since reset were both J.
- R6: `sop_o` pulses for one cycle after a K sample whose two preceding samples since reset were both J. A K with fewer idle samples before it gives no pulse.
- R7: With `eop_early_i` = 0, `eop_o` pulses on the strobe that follows a J sample, when the sample before that J was SE0.
- R8: With `eop_early_i` = 1, `eop_o` pulses right after a J sample whose preceding sample was SE0.
- R9: No other sample history produces `eop_o`. An SE0 followed by K or SE1, or SE0 with no J after it, gives no end-of-packet.
- R10: `sop_o`, `eop_o` and `se1_err_o` are high only in the cycle right after a strobe. They are never high in two consecutive cycles, and `sop_o` and `eop_o` are never high together.
- R11: While `rst_n` is low at a clock edge, the line state is reset to SE0 (00), all pulses and `idle_o` go low, and the sample history is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dp_i | input | 1 | Synchronised D+ level |
| dm_i | input | 1 | Synchronised D- level |
| low_speed_i | input | 1 | 1 = low-speed segment, 0 = full-speed segment |
| eop_early_i | input | 1 | 1 = first J sample after SE0 completes end-of-packet |
| bit_stb_i | input | 1 | One-cycle strobe, one per bit time |
| line_state_o | output | 2 | Classified bus state of the last sample |
| idle_o | output | 1 | Bus has been J for two bit times |
| sop_o | output | 1 | Start-of-packet pulse |
| eop_o | output | 1 | End-of-packet pulse |
| se1_err_o | output | 1 | Illegal SE1 sample pulse |

## Verification
The properties assume that `low_speed_i` and `eop_early_i` hold steady between resets. The bench sets them only while `rst_n` is low and keeps them fixed for a whole sample sequence. The properties also assume that the line inputs are steady around each strobe and that strobes are single cycles. The stimulus sets D+ and D- together with the strobe on the falling edge and always leaves at least one strobe-free cycle between samples. Within those limits, the bench sweeps every four-sample sequence of bus states for both speeds and both end-of-packet modes, with a reset before each sequence.

// File: rtl/usb_lsd_pkg.sv
// Package: shared types for the USB line state decoder.
// Assumes: nothing; only type definitions.
package usb_lsd_pkg;

    // Bus state code; the numeric values are visible on line_state_o.
    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_state_t;

    // Progress of end-of-packet recognition.
    typedef enum logic [1:0] {
        EOP_NONE  = 2'b00,
        EOP_SAW0  = 2'b01,
        EOP_JHOLD = 2'b10
    } eop_state_t;

endpackage

// File: rtl/usb_lsd_classify.sv
// Module: usb_lsd_classify
// Purely combinational mapping of the two line levels to a bus state.
// Assumes: dp/dm are already synchronised to clk; speed select is static.
module usb_lsd_classify
    import usb_lsd_pkg::*;
(
    input  logic        dp_i,
    input  logic        dm_i,
    input  logic        low_speed_i,
    output line_state_t state_o
);

    // Decode line pair; differential meaning flips with segment speed.
    always_comb begin
        unique case ({dp_i, dm_i})
            2'b00:   state_o = LS_SE0;
            2'b11:   state_o = LS_SE1;
            2'b01:   state_o = low_speed_i ? LS_J : LS_K;
            default: state_o = low_speed_i ? LS_K : LS_J;
        endcase
    end

endmodule

// File: rtl/usb_lsd_idle_track.sv
// Module: usb_lsd_idle_track
// Counts consecutive J samples (saturating) to form the idle indication,
// and flags start-of-packet when K follows a full idle period.
// Assumes: stb_i is a single-cycle strobe; cur_i is valid when stb_i is high.
module usb_lsd_idle_track
    import usb_lsd_pkg::*;
#(
    parameter int IDLE_BITS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        stb_i,
    input  line_state_t cur_i,
    output logic        idle_o,
    output logic        sop_o
);

    localparam int CNT_W = $clog2(IDLE_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(IDLE_BITS);

    logic [CNT_W-1:0] j_cnt;
    logic             idle_now;
    logic             sop_q;

    assign idle_now = (j_cnt >= CNT_MAX);

    // Track run length of J samples, cleared by any other state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            j_cnt <= '0;
        end else if (stb_i) begin
            if (cur_i != LS_J) begin
                j_cnt <= '0;
            end else if (!idle_now) begin
                j_cnt <= j_cnt + 1'b1;
            end
        end
    end

    // Pulse start-of-packet when K arrives on an idle bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sop_q <= 1'b0;
        end else begin
            sop_q <= stb_i && (cur_i == LS_K) && idle_now;
        end
    end

    assign idle_o = idle_now;
    assign sop_o  = sop_q;

endmodule

// File: rtl/usb_lsd_eop_detect.sv
// Module: usb_lsd_eop_detect
// Recognises end-of-packet: at least one SE0 sample, then J. In strict mode
// the J must be held for a full bit (pulse on the following strobe); in
// early mode the first J sample completes it.
// Assumes: early_i is static between resets; stb_i is a single-cycle strobe.
module usb_lsd_eop_detect
    import usb_lsd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        stb_i,
    input  logic        early_i,
    input  line_state_t cur_i,
    output logic        eop_o
);

    eop_state_t state_q, state_d;
    logic       fire_d, eop_q;

    // Next-state and pulse decision for one sample.
    always_comb begin
        state_d = state_q;
        fire_d  = 1'b0;
        if (stb_i) begin
            unique case (state_q)
                EOP_NONE: begin
                    if (cur_i == LS_SE0) state_d = EOP_SAW0;
                end
                EOP_SAW0: begin
                    if (cur_i == LS_SE0) begin
                        state_d = EOP_SAW0;
                    end else if (cur_i == LS_J) begin
                        if (early_i) begin
                            fire_d  = 1'b1;
                            state_d = EOP_NONE;
                        end else begin
                            state_d = EOP_JHOLD;
                        end
                    end else begin
                        state_d = EOP_NONE;
                    end
                end
                EOP_JHOLD: begin
                    fire_d  = 1'b1;
                    state_d = (cur_i == LS_SE0) ? EOP_SAW0 : EOP_NONE;
                end
                default: state_d = EOP_NONE;
            endcase
        end
    end

    // Register state and the single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EOP_NONE;
            eop_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            eop_q   <= fire_d;
        end
    end

    assign eop_o = eop_q;

endmodule

// File: rtl/usb_line_state_decoder.sv
// Module: usb_line_state_decoder (top)
// Samples D+/D- on each bit strobe, publishes the registered bus state,
// SE1 error pulse, idle indication and framing pulses.
// Assumes: lines synchronised upstream; low_speed_i and eop_early_i change
// only while in reset; bit_stb_i is high for one cycle per bit time.
module usb_line_state_decoder
    import usb_lsd_pkg::*;
#(
    parameter int IDLE_BITS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dp_i,
    input  logic       dm_i,
    input  logic       low_speed_i,
    input  logic       eop_early_i,
    input  logic       bit_stb_i,
    output logic [1:0] line_state_o,
    output logic       idle_o,
    output logic       sop_o,
    output logic       eop_o,
    output logic       se1_err_o
);

    line_state_t cur_state;
    line_state_t line_q;
    logic        se1_q;

    usb_lsd_classify i_classify (
        .dp_i        (dp_i),
        .dm_i        (dm_i),
        .low_speed_i (low_speed_i),
        .state_o     (cur_state)
    );

    usb_lsd_idle_track #(
        .IDLE_BITS (IDLE_BITS)
    ) i_idle (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb_i  (bit_stb_i),
        .cur_i  (cur_state),
        .idle_o (idle_o),
        .sop_o  (sop_o)
    );

    usb_lsd_eop_detect i_eop (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb_i   (bit_stb_i),
        .early_i (eop_early_i),
        .cur_i   (cur_state),
        .eop_o   (eop_o)
    );

    // Hold the classified state of the latest sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= LS_SE0;
        end else if (bit_stb_i) begin
            line_q <= cur_state;
        end
    end

    // Pulse the error flag for an illegal both-high sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            se1_q <= 1'b0;
        end else begin
            se1_q <= bit_stb_i && (cur_state == LS_SE1);
        end
    end

    assign line_state_o = line_q;
    assign se1_err_o    = se1_q;

endmodule

// File: rtl/usb_lsd_checker.sv
// Module: usb_lsd_checker
// Temporal properties on the decoder's ports; bound to the top module.
// Assumes: the input conditions listed in the brief's verification section.
module usb_lsd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       eop_early_i,
    input logic       bit_stb_i,
    input logic [1:0] line_state_o,
    input logic       idle_o,
    input logic       sop_o,
    input logic       eop_o,
    input logic       se1_err_o
);

    assert_line_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_stb_i) |-> $stable(line_state_o));

    assert_se1_is_se1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        se1_err_o |-> (line_state_o == 2'b11));

    assert_idle_is_j_R5: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> (line_state_o == 2'b01));

    assert_sop_on_k_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sop_o |-> (line_state_o == 2'b10));

    assert_early_eop_on_j_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eop_o && eop_early_i) |-> (line_state_o == 2'b01));

    assert_pulse_after_stb_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sop_o || eop_o || se1_err_o) |-> $past(bit_stb_i));

    assert_sop_eop_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(sop_o && eop_o));

    assert_sop_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sop_o |=> !sop_o);

    assert_eop_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        eop_o |=> !eop_o);

endmodule

bind usb_line_state_decoder usb_lsd_checker i_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .eop_early_i  (eop_early_i),
    .bit_stb_i    (bit_stb_i),
    .line_state_o (line_state_o),
    .idle_o       (idle_o),
    .sop_o        (sop_o),
    .eop_o        (eop_o),
    .se1_err_o    (se1_err_o)
);

// File: tb/test_usb_line_state_decoder.sv
// Bench: sweeps every 4-sample bus state sequence for both speeds and both
// end-of-packet modes; expected values come from a sample-history model.
module test_usb_line_state_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dp_i = 1'b0, dm_i = 1'b0;
    logic       low_speed_i = 1'b0, eop_early_i = 1'b0, bit_stb_i = 1'b0;
    logic [1:0] line_state_o;
    logic       idle_o, sop_o, eop_o, se1_err_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    // history: 0 SE0, 1 J, 2 K, 3 SE1, 4 none (after reset)
    int h1, h2;

    usb_line_state_decoder i_usb_line_state_decoder (
        .clk          (clk),
        .rst_n        (rst_n),
        .dp_i         (dp_i),
        .dm_i         (dm_i),
        .low_speed_i  (low_speed_i),
        .eop_early_i  (eop_early_i),
        .bit_stb_i    (bit_stb_i),
        .line_state_o (line_state_o),
        .idle_o       (idle_o),
        .sop_o        (sop_o),
        .eop_o        (eop_o),
        .se1_err_o    (se1_err_o)
    );

    always #5 clk = ~clk;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_fails++;
                $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
                summary();
                $finish;
            end
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic do_reset(bit low, bit early);
        @(negedge clk);
        rst_n = 1'b0; bit_stb_i = 1'b0; dp_i = 1'b0; dm_i = 1'b0;
        low_speed_i = low; eop_early_i = early;
        @(negedge clk);
        @(negedge clk);
        chk("R11", "line after reset", int'(line_state_o), 0);
        chk("R11", "flags after reset", int'({idle_o, sop_o, eop_o, se1_err_o}), 0);
        rst_n = 1'b1;
        h1 = 4; h2 = 4;
    endtask

    // Apply one sample of bus state sym and check all outputs.
    task automatic apply(int sym);
        int exp_eop, exp_sop, exp_idle, exp_err;
        string ltag, etag;
        case (sym)
            0: begin dp_i = 1'b0; dm_i = 1'b0; end
            3: begin dp_i = 1'b1; dm_i = 1'b1; end
            1: begin dp_i = !low_speed_i; dm_i = low_speed_i; end
            default: begin dp_i = low_speed_i; dm_i = !low_speed_i; end
        endcase
        bit_stb_i = 1'b1;
        @(negedge clk);
        bit_stb_i = 1'b0;
        exp_idle = (sym == 1 && h1 == 1) ? 1 : 0;
        exp_sop  = (sym == 2 && h1 == 1 && h2 == 1) ? 1 : 0;
        exp_err  = (sym == 3) ? 1 : 0;
        if (eop_early_i) exp_eop = (sym == 1 && h1 == 0) ? 1 : 0;
        else             exp_eop = (h1 == 1 && h2 == 0) ? 1 : 0;
        ltag = low_speed_i ? "R2" : "R3";
        etag = (exp_eop == 0) ? "R9" : (eop_early_i ? "R8" : "R7");
        chk(ltag, "line state", int'(line_state_o), sym);
        chk("R5", "idle", int'(idle_o), exp_idle);
        chk("R6", "sop", int'(sop_o), exp_sop);
        chk(etag, "eop", int'(eop_o), exp_eop);
        chk("R4", "se1 error", int'(se1_err_o), exp_err);
        h2 = h1; h1 = sym;
        // Strobe-free cycle: state holds, pulses drop.
        @(negedge clk);
        chk("R1", "line held", int'(line_state_o), sym);
        chk("R10", "pulses cleared", int'({sop_o, eop_o, se1_err_o}), 0);
    endtask

    initial begin
        h1 = 4; h2 = 4;
        for (int mode = 0; mode < 4; mode++) begin
            for (int seq = 0; seq < 256; seq++) begin
                do_reset(mode[0], mode[1]);
                for (int k = 0; k < 4; k++) begin
                    apply((seq >> (2 * k)) & 3);
                end
            end
        end
        summary();
        $finish;
    end

endmodule